// File: doc/BRIEF.md
# Dual-Core Software Interrupt Flag Register

This block holds one software interrupt pending flag for each of two processor cores and lets either core raise or drop any flag through a single 32-bit register word. Each core reaches the register through its own access port: valid, write enable, write data and read data. A write names the flags to raise in one bit field and the flags to drop in another. Writing 0 to any bit leaves the matching flag alone, so each core can change one flag without reading the word first.

Each flag drives the machine-level software interrupt pending input of its core directly. It is not merged into any shared system interrupt line. Both cores may write in the same cycle. The raise and drop requests from both ports are OR-combined first and then applied together. Any flag that gets a raise request in that cycle ends up set, even if it also gets a drop request. A read returns the flag state held before any write in that same cycle.

Top module: `swirq_regs`

## Requirements
- R1: While `rst` is high at a clock edge, both flags are 0 after that edge, so `sw_irq_pend` is 0.
- R2: A write with bit 0 = 1 sets the core 0 flag. A write with bit 1 = 1 sets the core 1 flag. The flag is 1 after the next rising edge.
- R3: A write with bit 2 = 1 clears the core 0 flag. A write with bit 3 = 1 clears the core 1 flag. This holds when no port requests a set of that flag in the same cycle.
- R4: A 0 in any set or clear bit has no effect. A flag that receives no request keeps its value.
- R5: While a port's `valid` is high, its read data holds the core 0 flag in bits 0 and 2 and the core 1 flag in bits 1 and 3. All other bits read 0. While `valid` is low, the read data is all zero.
- R6: Read data in the cycle of a write shows the flag values from before that write.
- R7: When both ports write in the same cycle, every set and clear request from either port takes effect.
- R8: A flag that receives a set request and a clear request in the same cycle ends up 1. This holds whether both requests come from the same port or from different ports.
- R9: A port changes nothing unless `valid` and `we` are both high in the same cycle.
- R10: `sw_irq_pend[c]` equals the flag of core c at all times.
- R11: Write data bits 4 to 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Core 0 port access strobe |
| p0_we | input | 1 | Core 0 port write enable |
| p0_wdata | input | 32 | Core 0 port write data |
| p0_rdata | output | 32 | Core 0 port read data |
| p1_valid | input | 1 | Core 1 port access strobe |
| p1_we | input | 1 | Core 1 port write enable |
| p1_wdata | input | 32 | Core 1 port write data |
| p1_rdata | output | 32 | Core 1 port read data |
| sw_irq_pend | output | 2 | Software interrupt pending, one bit per core |

## Verification
The assertions check the following on every cycle:
- Any set request leaves its flag at 1 on the next edge.
- A clear request with no competing set leaves its flag at 0.
- A flag with no request holds its value.
- Idle ports leave the flags unchanged.
- Read data mirrors the flags and is zero when the port is not selected.

Only the bench scenarios can show these points:
- The merged result of specific two-port mixes, such as one core setting a flag while the other clears it.
- The read returning the value from before a write in that same cycle.
- High write-data bits being ignored.
- Reset arriving while flags are set.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

  // Set field occupies the low NUM_CORES bits; clear field follows directly.
  function automatic int set_pos(input int core);
    return core;
  endfunction

  function automatic int clr_pos(input int core, input int ncores);
    return ncores + core;
  endfunction

endpackage

// File: rtl/swirq_port_decode.sv
module swirq_port_decode #(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 2
) (
  input  logic                 valid,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_CORES-1:0] flags,
  output logic [NUM_CORES-1:0] set_req,
  output logic [NUM_CORES-1:0] clr_req,
  output logic [DATA_W-1:0]    rdata
);
  import swirq_pkg::*;

  localparam int FIELD_W = 2 * NUM_CORES;

  logic wr_hit;
  logic unused_hi;

  assign wr_hit    = valid & we;
  assign unused_hi = ^wdata[DATA_W-1:FIELD_W];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign set_req[c] = wr_hit & wdata[set_pos(c)];
    assign clr_req[c] = wr_hit & wdata[clr_pos(c, NUM_CORES)];
  end

  always_comb begin
    rdata = '0;
    if (valid) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        rdata[set_pos(c)]            = flags[c];
        rdata[clr_pos(c, NUM_CORES)] = flags[c];
      end
    end
  end

endmodule

// File: rtl/swirq_merge.sv
module swirq_merge #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_CORES = 2
) (
  input  logic [NUM_PORTS-1:0][NUM_CORES-1:0] set_all,
  input  logic [NUM_PORTS-1:0][NUM_CORES-1:0] clr_all,
  output logic [NUM_CORES-1:0]                any_set,
  output logic [NUM_CORES-1:0]                any_clr
);

  always_comb begin
    any_set = '0;
    any_clr = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      any_set = any_set | set_all[p];
      any_clr = any_clr | clr_all[p];
    end
  end

endmodule

// File: rtl/swirq_flag_bank.sv
module swirq_flag_bank #(
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] set_req,
  input  logic [NUM_CORES-1:0] clr_req,
  output logic [NUM_CORES-1:0] flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_req) | set_req;
    end
  end

  // R1: reset empties every flag
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (flags == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    // R8: a set request always wins
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_req[c] |=> flags[c]);
    // R3: an uncontested clear drops the flag
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_req[c] && !set_req[c]) |=> !flags[c]);
    // R4: no request, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr_req[c] && !set_req[c]) |=> $stable(flags[c]));
  end

endmodule

// File: rtl/swirq_regs.sv
module swirq_regs #(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 p0_valid,
  input  logic                 p0_we,
  input  logic [DATA_W-1:0]    p0_wdata,
  output logic [DATA_W-1:0]    p0_rdata,
  input  logic                 p1_valid,
  input  logic                 p1_we,
  input  logic [DATA_W-1:0]    p1_wdata,
  output logic [DATA_W-1:0]    p1_rdata,
  output logic [NUM_CORES-1:0] sw_irq_pend
);

  localparam int NUM_PORTS = 2;

  logic [NUM_PORTS-1:0]                valid_v;
  logic [NUM_PORTS-1:0]                we_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata_v;
  logic [NUM_PORTS-1:0][NUM_CORES-1:0] set_v;
  logic [NUM_PORTS-1:0][NUM_CORES-1:0] clr_v;
  logic [NUM_CORES-1:0]                any_set;
  logic [NUM_CORES-1:0]                any_clr;
  logic [NUM_CORES-1:0]                flags;

  assign valid_v = {p1_valid, p0_valid};
  assign we_v    = {p1_we, p0_we};
  assign wdata_v = {p1_wdata, p0_wdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    swirq_port_decode #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES)) u_dec (
      .valid   (valid_v[p]),
      .we      (we_v[p]),
      .wdata   (wdata_v[p]),
      .flags   (flags),
      .set_req (set_v[p]),
      .clr_req (clr_v[p]),
      .rdata   (rdata_v[p])
    );
  end

  swirq_merge #(.NUM_PORTS(NUM_PORTS), .NUM_CORES(NUM_CORES)) u_merge (
    .set_all (set_v),
    .clr_all (clr_v),
    .any_set (any_set),
    .any_clr (any_clr)
  );

  swirq_flag_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_req (any_set),
    .clr_req (any_clr),
    .flags   (flags)
  );

  assign p0_rdata    = rdata_v[0];
  assign p1_rdata    = rdata_v[1];
  assign sw_irq_pend = flags;

  // R9: idle ports leave the flags unchanged
  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (!(p0_valid && p0_we) && !(p1_valid && p1_we)) |=> $stable(sw_irq_pend));
  // R5: unselected port reads zero
  a_r5_p0_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !p0_valid |-> (p0_rdata == '0));
  a_r5_p1_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !p1_valid |-> (p1_rdata == '0));
  // R5: selected port mirrors the pending outputs in the set field
  a_r5_p0_mirror: assert property (@(posedge clk) disable iff (rst)
    p0_valid |-> (p0_rdata[NUM_CORES-1:0] == sw_irq_pend));
  // R7: a set from the second port reaches core 0 even amid other traffic
  a_r7_p1_sets_core0: assert property (@(posedge clk) disable iff (rst)
    (p1_valid && p1_we && p1_wdata[0]) |=> sw_irq_pend[0]);

endmodule

// File: tb/tb_swirq_regs.sv
`timescale 1ns/1ps
module tb_swirq_regs;

  localparam int DW = 32;
  localparam int NC = 2;

  typedef struct packed {
    logic       v0;
    logic       w0;
    logic [3:0] d0;
    logic       v1;
    logic       w1;
    logic [3:0] d1;
    logic [1:0] exp;
  } vec_t;

  localparam int NV = 12;
  // Field positions: bit0 set c0, bit1 set c1, bit2 clr c0, bit3 clr c1.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 4'h1, 1'b0, 1'b0, 4'h0, 2'b01}, // R2 p0 sets c0
    '{1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'h2, 2'b11}, // R2 p1 sets c1
    '{1'b1, 1'b1, 4'h4, 1'b0, 1'b0, 4'h0, 2'b10}, // R3 p0 clears c0
    '{1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'h1, 2'b10}, // R9 read only
    '{1'b0, 1'b1, 4'h1, 1'b0, 1'b0, 4'h0, 2'b10}, // R9 we without valid
    '{1'b1, 1'b1, 4'h1, 1'b1, 1'b1, 4'h4, 2'b11}, // R8 set vs clear across ports
    '{1'b1, 1'b1, 4'hC, 1'b0, 1'b0, 4'h0, 2'b00}, // R3 clear both
    '{1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 4'h0, 2'b01}, // R8 same-port set+clear
    '{1'b1, 1'b1, 4'h2, 1'b1, 1'b1, 4'h1, 2'b11}, // R7 both ports set
    '{1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 4'h8, 2'b01}, // R4 zero write + clear c1
    '{1'b1, 1'b1, 4'h4, 1'b1, 1'b1, 4'h8, 2'b00}, // R7 both ports clear
    '{1'b1, 1'b1, 4'hA, 1'b1, 1'b1, 4'h8, 2'b10}  // R8 set c1 vs two clears
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          p0_valid, p0_we, p1_valid, p1_we;
  logic [DW-1:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
  logic [NC-1:0] sw_irq_pend;

  int   errors  = 0;
  int   nchecks = 0;
  logic done    = 1'b0;

  always #2.5 clk = ~clk;

  swirq_regs #(.DATA_W(DW), .NUM_CORES(NC)) dut (
    .clk(clk), .rst(rst),
    .p0_valid(p0_valid), .p0_we(p0_we), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_valid(p1_valid), .p1_we(p1_we), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .sw_irq_pend(sw_irq_pend)
  );

  function automatic logic [DW-1:0] rd_img(input logic [1:0] f);
    return {{(DW-4){1'b0}}, f[1], f[0], f[1], f[0]};
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0, 1:        return "R2";
      2, 6:        return "R3";
      3, 4:        return "R9";
      9:           return "R4";
      8, 10:       return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchecks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    p0_valid = 1'b0; p0_we = 1'b0; p0_wdata = '0;
    p1_valid = 1'b0; p1_we = 1'b0; p1_wdata = '0;
  endtask

  initial begin
    #(50000 * 5);
    if (!done) begin
      errors++;
      nchecks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pending after reset", {30'b0, sw_irq_pend}, '0);
    rst = 1'b0;
    p0_valid = 1'b1;
    #1 chk("R1 readback after reset", p0_rdata, '0);
    idle();
    prev = 2'b00;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      p0_valid = VEC[i].v0; p0_we = VEC[i].w0; p0_wdata = {28'h0, VEC[i].d0};
      p1_valid = VEC[i].v1; p1_we = VEC[i].w1; p1_wdata = {28'h0, VEC[i].d1};
      #1;
      chk("R5/R6 port0 read in write cycle", p0_rdata, VEC[i].v0 ? rd_img(prev) : '0);
      chk("R5/R6 port1 read in write cycle", p1_rdata, VEC[i].v1 ? rd_img(prev) : '0);
      @(negedge clk);
      idle();
      #1;
      chk($sformatf("%s R10 vector %0d", tag_of(i), i), {30'b0, sw_irq_pend}, {30'b0, VEC[i].exp});
      prev = VEC[i].exp;
    end

    // R11: high bits alone do nothing
    @(negedge clk);
    p0_valid = 1'b1; p0_we = 1'b1; p0_wdata = 32'hFFFF_FFF0;
    @(negedge clk); idle(); #1;
    chk("R11 high bits ignored", {30'b0, sw_irq_pend}, 32'h2);

    // R11: high bits mixed with a set of core 0
    @(negedge clk);
    p1_valid = 1'b1; p1_we = 1'b1; p1_wdata = 32'h5A5A_5A51;
    @(negedge clk); idle(); #1;
    chk("R11 set through noisy word", {30'b0, sw_irq_pend}, 32'h3);

    // R5: full read image with both flags set
    p1_valid = 1'b1;
    #1 chk("R5 read image both set", p1_rdata, 32'h0000_000F);
    idle();

    // R1: reset while flags are set
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R1 reset mid-run", {30'b0, sw_irq_pend}, '0);
    p0_valid = 1'b1;
    #1 chk("R1 readback after mid-run reset", p0_rdata, '0);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end

endmodule